// File: doc/BRIEF.md
# Packed BCD String Add Sequencer

This block adds one packed decimal string into another, a byte at a time. A start pulse hands it a digit count and two 16-bit base offsets. Each byte holds two decimal digits. For every byte the block reads the source byte, reads the destination byte, adds them with the decimal carry from the previous byte, and writes the sum back over the destination byte. Both offsets then advance by one.

The block runs its own byte-wide memory bus. Every transfer takes four cycles, and the idle gaps between transfers are fixed. As a result each byte iteration takes exactly 22 cycles. The number of iterations comes from an internal down-counter. The counter is loaded from the digit count rounded up to whole bytes. The rounding is done in 8-bit arithmetic, so the load can wrap to zero. The counter is decremented before it is tested for zero, so a zero load runs the full counter range.

Top module: `bcd_str_seq`

## Requirements
- R1: While reset is held and while idle, busReq, busStrobe, busy and done are all low.
- R2: A start seen while idle loads the iteration counter with the 8-bit value (digitCount + 1) >> 1. The first source transfer begins in the cycle after start, so digit counts 1 and 2 each run one byte.
- R3: The counter is CNT_W bits wide (default 16) and is decremented before the zero test. A digit count of 0 or 255 loads 0 and so runs 2^CNT_W iterations.
- R4: Each iteration is 22 cycles. Transfer starts fall at cycle offsets 0, 7 and 16 of the iteration. The first is the source read (busSeg=0, busWrite=0), the second is the destination read (busSeg=1, busWrite=0) and the third is the destination write (busSeg=1, busWrite=1).
- R5: Each transfer holds busReq high for exactly 4 cycles. busStrobe is high in its 2nd and 3rd cycles only, and read data is captured at the end of the 3rd cycle.
- R6: busAddr equals the base offset plus the iteration index, taken modulo 2^16. The source base is used for source reads and the destination base for destination transfers.
- R7: The written byte is the packed decimal sum of the two bytes plus the carry in. Bits [3:0] hold the low digit and bits [7:4] the high digit. The carry starts at 0 on each start and passes to the next byte.
- R8: done is high for exactly one cycle, the cycle right after the T4 of the final write. busy is high through that cycle and low after it.
- R9: A start that arrives while busy has no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| digitCount | input | 8 | Number of decimal digits |
| srcBase | input | 16 | Source starting offset |
| dstBase | input | 16 | Destination starting offset |
| busReq | output | 1 | Transfer in progress (T1 to T4) |
| busWrite | output | 1 | Transfer is a write |
| busSeg | output | 1 | 0 = source space, 1 = destination space |
| busStrobe | output | 1 | Data strobe (T2 and T3) |
| busAddr | output | 16 | Byte offset of the transfer |
| busWData | output | 8 | Write data |
| busRData | input | 8 | Read data, captured at the end of T3 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that every byte returned on busRData holds two valid decimal digits (0 to 9). They also assume that read data is stable when it is captured at the end of T3. The bench keeps to both assumptions. Its memory model answers reads combinationally from arrays that are filled only with digits drawn from $urandom modulo ten. The directed corner cases use only hand-chosen valid decimal patterns.

// File: rtl/bcd_seq_pkg.sv
package bcd_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_DONE = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // accept start: latch bases, clear carry
    logic capSrc;  // capture source byte (end of T3)
    logic capDst;  // capture destination byte (end of T3)
    logic commit;  // end of write T4: keep carry, step offsets
    logic selDst;  // address mux: destination offset
  } seqCtrl_t;

endpackage

// File: rtl/bcd_seq_ctrl.sv
module bcd_seq_ctrl
  import bcd_seq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int XFER_LEN = 4,
  parameter int GAP_SRC  = 3,
  parameter int GAP_DST  = 5,
  parameter int GAP_WR   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] digitCount,
  output seqCtrl_t   ctl,
  output logic       busReq,
  output logic       busWrite,
  output logic       busSeg,
  output logic       busStrobe,
  output logic       busy,
  output logic       done
);

  localparam int SRC_T1   = 0;
  localparam int DST_T1   = SRC_T1 + XFER_LEN + GAP_SRC;
  localparam int WR_T1    = DST_T1 + XFER_LEN + GAP_DST;
  localparam int ITER_LEN = WR_T1 + XFER_LEN + GAP_WR;
  localparam int SLOT_W   = $clog2(ITER_LEN);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(ITER_LEN - 1);
  localparam logic [SLOT_W-1:0] SLOT_WRT4 = SLOT_W'(WR_T1 + XFER_LEN - 1);

  seqState_t          state;
  logic [SLOT_W-1:0]  slot;
  logic [CNT_W-1:0]   cnt;
  logic [7:0]         cntSum8;
  logic [7:0]         cntLoad8;
  logic               running;
  logic               inSrc, inDst, inWr;
  logic [SLOT_W-1:0]  tIdx;

  // Byte count in 8-bit arithmetic; wraps for a digit count of 255
  always_comb begin
    cntSum8  = digitCount + 8'd1;
    cntLoad8 = cntSum8 >> 1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      slot  <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_RUN;
            slot  <= '0;
            cnt   <= CNT_W'(cntLoad8);
          end
        end
        S_RUN: begin
          if (slot == SLOT_WRT4) begin
            cnt <= cnt - 1'b1;  // decrement, then test
            if (cnt == CNT_W'(1)) state <= S_DONE;
            slot <= slot + 1'b1;
          end else if (slot == SLOT_LAST) begin
            slot <= '0;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    running = (state == S_RUN);
    inSrc   = running && (slot < SLOT_W'(SRC_T1 + XFER_LEN));
    inDst   = running && (slot >= SLOT_W'(DST_T1)) && (slot < SLOT_W'(DST_T1 + XFER_LEN));
    inWr    = running && (slot >= SLOT_W'(WR_T1))  && (slot < SLOT_W'(WR_T1 + XFER_LEN));
    if (inSrc)      tIdx = slot - SLOT_W'(SRC_T1);
    else if (inDst) tIdx = slot - SLOT_W'(DST_T1);
    else            tIdx = slot - SLOT_W'(WR_T1);
    busReq     = inSrc || inDst || inWr;
    busStrobe  = busReq && (tIdx == SLOT_W'(1) || tIdx == SLOT_W'(2));
    busWrite   = inWr;
    busSeg     = inDst || inWr;
    busy       = (state != S_IDLE);
    done       = (state == S_DONE);
    ctl.load   = (state == S_IDLE) && start;
    ctl.capSrc = inSrc && (tIdx == SLOT_W'(2));
    ctl.capDst = inDst && (tIdx == SLOT_W'(2));
    ctl.commit = inWr && (tIdx == SLOT_W'(XFER_LEN - 1));
    ctl.selDst = inDst || inWr;
  end

  p_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busReq && !busStrobe));

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> (cnt == $past(cnt) - 1'b1));

  p_write_seg_r4: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> busSeg);

  p_strobe_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |-> busReq);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |=> busReq);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (running && start && !ctl.commit) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/bcd_seq_dp.sv
module bcd_seq_dp
  import bcd_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIGITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctl,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [4*DIGITS-1:0] busRData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [4*DIGITS-1:0] busWData
);

  localparam int BYTE_W = 4 * DIGITS;

  logic [ADDR_W-1:0] srcOff, dstOff;
  logic [BYTE_W-1:0] srcByte, dstByte;
  logic              carry;
  logic [DIGITS:0]   digCarry;
  logic [BYTE_W-1:0] sumByte;

  assign digCarry[0] = carry;

  // Digit-serial decimal adder, one stage per nibble
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [4:0] raw;
    logic       adj;
    logic [4:0] fixed;
    always_comb begin
      raw   = {1'b0, srcByte[4*g +: 4]} + {1'b0, dstByte[4*g +: 4]} + {4'd0, digCarry[g]};
      adj   = (raw > 5'd9);
      fixed = adj ? (raw + 5'd6) : raw;
    end
    assign sumByte[4*g +: 4] = fixed[3:0];
    assign digCarry[g+1]     = adj;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcOff  <= '0;
      dstOff  <= '0;
      srcByte <= '0;
      dstByte <= '0;
      carry   <= 1'b0;
    end else begin
      if (ctl.load) begin
        srcOff <= srcBase;
        dstOff <= dstBase;
        carry  <= 1'b0;
      end
      if (ctl.capSrc) srcByte <= busRData;
      if (ctl.capDst) dstByte <= busRData;
      if (ctl.commit) begin
        carry  <= digCarry[DIGITS];
        srcOff <= srcOff + 1'b1;
        dstOff <= dstOff + 1'b1;
      end
    end
  end

  assign busAddr  = ctl.selDst ? dstOff : srcOff;
  assign busWData = sumByte;

  p_off_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> (srcOff == $past(srcOff) + 1'b1) && (dstOff == $past(dstOff) + 1'b1));

  p_carry_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> !carry);

  p_digit_ok_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |-> (sumByte[3:0] <= 4'd9));

endmodule

// File: rtl/bcd_str_seq.sv
module bcd_str_seq
  import bcd_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  digitCount,
  input  logic [15:0] srcBase,
  input  logic [15:0] dstBase,
  output logic        busReq,
  output logic        busWrite,
  output logic        busSeg,
  output logic        busStrobe,
  output logic [15:0] busAddr,
  output logic [7:0]  busWData,
  input  logic [7:0]  busRData,
  output logic        busy,
  output logic        done
);

  seqCtrl_t ctl;

  bcd_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .digitCount (digitCount),
    .ctl        (ctl),
    .busReq     (busReq),
    .busWrite   (busWrite),
    .busSeg     (busSeg),
    .busStrobe  (busStrobe),
    .busy       (busy),
    .done       (done)
  );

  bcd_seq_dp #(.ADDR_W(16), .DIGITS(2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .srcBase  (srcBase),
    .dstBase  (dstBase),
    .busRData (busRData),
    .busAddr  (busAddr),
    .busWData (busWData)
  );

endmodule

// File: tb/bcd_str_seq_tb.sv
module bcd_str_seq_tb;

  localparam int CW   = 10;   // reduced counter width keeps the wrap case short
  localparam int MEMN = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  digitCount = '0;
  logic [15:0] srcBase = '0, dstBase = '0;
  logic        busReq, busWrite, busSeg, busStrobe, busy, done;
  logic [15:0] busAddr;
  logic [7:0]  busWData, busRData;

  logic [7:0] sMem [MEMN];
  logic [7:0] dMem [MEMN];
  logic [7:0] refD [MEMN];

  int nChecks = 0, nFails = 0, wd = 0;
  bit wdFired = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bcd_str_seq #(.CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .digitCount(digitCount),
    .srcBase(srcBase), .dstBase(dstBase), .busReq(busReq), .busWrite(busWrite),
    .busSeg(busSeg), .busStrobe(busStrobe), .busAddr(busAddr), .busWData(busWData),
    .busRData(busRData), .busy(busy), .done(done)
  );

  assign busRData = busSeg ? dMem[busAddr[9:0]] : sMem[busAddr[9:0]];

  always @(posedge clk) begin
    if (busReq && busWrite && busStrobe) dMem[busAddr[9:0]] <= busWData;
    wd <= wd + 1;
    if (wd > 190000) wdFired <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // decimal reference computed through integer arithmetic
  function automatic logic [8:0] decAdd(input logic [7:0] a, input logic [7:0] b, input logic c);
    int va, vb, s;
    va = int'(a[7:4]) * 10 + int'(a[3:0]);
    vb = int'(b[7:4]) * 10 + int'(b[3:0]);
    s  = va + vb + int'(c);
    return {(s >= 100), 4'((s / 10) % 10), 4'(s % 10)};
  endfunction

  function automatic int expIters(input logic [7:0] d);
    int t;
    t = ((int'(d) + 1) % 256) / 2;
    return (t == 0) ? (1 << CW) : t;
  endfunction

  function automatic logic [7:0] rndBcd();
    return {4'($urandom % 10), 4'($urandom % 10)};
  endfunction

  task automatic fillRandom();
    for (int i = 0; i < MEMN; i++) begin
      sMem[i] = rndBcd();
      dMem[i] = rndBcd();
    end
  endtask

  // per-cycle bus observer
  int  cyc, xfer, runLen;
  bit  prevReq;
  logic [15:0] curSrc, curDst;

  task automatic sampleCycle();
    int k, it, expCyc;
    logic [15:0] expA;
    if (busReq && !prevReq) begin
      k  = xfer % 3;
      it = xfer / 3;
      expCyc = 22 * it + ((k == 0) ? 1 : (k == 1) ? 8 : 17);
      chk(cyc == expCyc, (it == 0 && k == 0) ? "R2" : "R4", "transfer start cycle", cyc, expCyc);
      chk(busSeg == (k != 0) && busWrite == (k == 2), "R4", "transfer kind seg/write",
          {busSeg, busWrite}, {(k != 0), (k == 2)});
      expA = (k == 0) ? 16'(curSrc + 16'(it)) : 16'(curDst + 16'(it));
      chk(busAddr == expA, "R6", "transfer address", busAddr, expA);
      xfer++;
      runLen = 0;
    end
    if (busReq) begin
      runLen++;
      if (busStrobe != (runLen == 2 || runLen == 3))
        chk(1'b0, "R5", "strobe phase", runLen, -1);
    end
    if (!busReq && prevReq) chk(runLen == 4, "R5", "request length", runLen, 4);
    prevReq = busReq;
  endtask

  task automatic runOp(input logic [7:0] d, input logic [15:0] sb, input logic [15:0] db,
                       input int pokeAt, input string req);
    int n, expDone;
    logic c;
    logic [8:0] r;
    bit mism;
    int badIdx;
    n = expIters(d);
    for (int i = 0; i < MEMN; i++) refD[i] = dMem[i];
    c = 1'b0;
    for (int i = 0; i < n; i++) begin
      r = decAdd(sMem[10'(sb + 16'(i))], refD[10'(db + 16'(i))], c);
      refD[10'(db + 16'(i))] = r[7:0];
      c = r[8];
    end
    @(negedge clk);
    digitCount = d; srcBase = sb; dstBase = db; start = 1'b1;
    curSrc = sb; curDst = db;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; xfer = 0; runLen = 0; prevReq = 1'b0;
    expDone = 22 * (n - 1) + 21;
    forever begin
      sampleCycle();
      if (done) begin
        chk(cyc == expDone, req, "done cycle", cyc, expDone);
        chk(busy == 1'b1, "R8", "busy during done", busy, 1);
        break;
      end
      if (wdFired) break;
      if (cyc == pokeAt) begin
        start = 1'b1; digitCount = d ^ 8'h5A; srcBase = ~sb; dstBase = ~db;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    @(negedge clk);
    chk(!done && !busy, "R8", "done single pulse, busy cleared", {done, busy}, 0);
    chk(xfer == 3 * n, req, "transfer count", xfer, 3 * n);
    mism = 1'b0; badIdx = 0;
    for (int i = 0; i < MEMN; i++)
      if (!mism && dMem[i] !== refD[i]) begin mism = 1'b1; badIdx = i; end
    chk(!mism, "R7", "destination contents", dMem[badIdx], refD[badIdx]);
  endtask

  initial begin
    void'($urandom(32'd24681));
    fillRandom();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busReq && !busStrobe && !busy && !done, "R1", "outputs in reset",
        {busReq, busStrobe, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busReq && !busStrobe && !busy && !done, "R1", "outputs idle after reset",
        {busReq, busStrobe, busy, done}, 0);

    runOp(8'd1, 16'h0010, 16'h0200, -1, "R2");
    runOp(8'd2, 16'h0011, 16'h0201, -1, "R2");
    runOp(8'd7, 16'h0020, 16'h0220, -1, "R2");

    // carry chained across bytes: 9999 + 0001
    sMem[16'h40] = 8'h99; sMem[16'h41] = 8'h99; sMem[16'h42] = 8'h00;
    dMem[16'h140] = 8'h01; dMem[16'h141] = 8'h00; dMem[16'h142] = 8'h00;
    runOp(8'd6, 16'h0040, 16'h0140, -1, "R7");
    chk(dMem[16'h142] == 8'h01, "R7", "carry reaches third byte", dMem[16'h142], 8'h01);

    // offsets wrap within 16 bits
    runOp(8'd8, 16'hFFFF, 16'hFFFE, -1, "R6");

    // start while busy is ignored
    runOp(8'd9, 16'h0300, 16'h0080, 30, "R9");
    runOp(8'd5, 16'h0310, 16'h0090, 3, "R9");

    // zero-load cases run the full counter range
    runOp(8'd255, 16'h0000, 16'h0000, -1, "R3");
    runOp(8'd0, 16'h0123, 16'h0321, -1, "R3");

    for (int t = 0; t < 14; t++) begin
      fillRandom();
      runOp(8'($urandom_range(1, 60)), 16'($urandom), 16'($urandom),
            (t == 5) ? 50 : -1, "R4");
    end

    if (wdFired) chk(1'b0, "R8", "watchdog expired", wd, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule